// File: doc/BRIEF.md
# Control Response Rate Selector

This block picks the transmit rate for an automatically generated control response, such as an acknowledgement or a clear-to-send, based on the rate of the received frame that prompted it. Two 16-bit rate bitmaps are supplied: a preferred set and a fallback set. Each bit position stands for one data rate. Legacy rates sit in slots 0 to 3: 1, 2, 5.5 and 11 Mb/s. Multicarrier rates sit in slots 8 to 15: 6, 9, 12, 18, 24, 36, 48 and 54 Mb/s. Slots 4 to 7 carry no rate. The two families together form mask 0xFF0F.

A request strobe arrives with the received rate as a 4-bit slot index. The block builds a cap mask that holds every defined rate no faster than the received one. It then takes the fastest preferred-set rate under that cap. If the preferred set has none, it takes the fastest fallback-set rate under the cap. Speed, not bit position, sets the ordering. For example, 6 and 9 Mb/s (slots 8 and 9) are slower than 11 Mb/s (slot 3). The result is a slot index plus an error flag. It is registered and reported one clock after the strobe.

Top module: `rrs_resp_rate_sel`

## Requirements
- R1: While reset is active and after it is released, rsp_valid_o, rsp_slot_o and rsp_err_o are all 0.
- R2: rsp_valid_o is 1 in exactly the cycle after each cycle in which req_i is 1, and 0 in every other cycle.
- R3: When rx_slot_i names a defined rate, rsp_slot_o is the slot of the fastest rate that is set in basic_map_i and is no faster than the received rate, and rsp_err_o is 0.
- R4: Comparisons use the speed order 1, 2, 5.5, 6, 9, 11, 12, 18, 24, 36, 48, 54 Mb/s, which corresponds to slots 0, 1, 2, 8, 9, 3, 10, 11, 12, 13, 14, 15. The bit position of a slot does not decide the order.
- R5: When no basic rate qualifies, rsp_slot_o is the fastest qualifying rate from mand_map_i, and rsp_err_o is 0.
- R6: When neither map holds a qualifying rate, rsp_slot_o is 0 (the 1 Mb/s slot) and rsp_err_o is 1.
- R7: A received slot index of 4, 5, 6 or 7 is invalid. The response is then slot 0 with rsp_err_o at 1, whatever the maps hold.
- R8: Bits 4 to 7 of either map never select a response. Map contents made only of those bits behave like an empty map.
- R9: rsp_slot_o and rsp_err_o change only in the cycle after a request, and they hold their value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Request strobe, one cycle per response |
| rx_slot_i | input | 4 | Slot index of the received frame's rate |
| basic_map_i | input | 16 | Preferred rate bitmap |
| mand_map_i | input | 16 | Fallback rate bitmap |
| rsp_valid_o | output | 1 | Result valid, one cycle after req_i |
| rsp_slot_o | output | 4 | Selected response rate slot index |
| rsp_err_o | output | 1 | No qualifying rate, or invalid received index |

## Verification
A wrong entry in the internal speed ranking appears at the ports as a response that is too slow or too fast, in the first result whose cap or winner involves the mis-ranked slot. Mixed-family maps, such as 6 and 9 Mb/s against 11 Mb/s, expose such an entry quickly. A broken fallback path or a broken cap mask shows as a wrong slot or a wrong error flag in the single valid cycle that follows the request. No later cycle is involved, so every fault is visible within one clock of the strobe that triggers it.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  localparam int unsigned SLOT_CNT   = 16;
  localparam int unsigned SLOT_IDX_W = $clog2(SLOT_CNT);
  localparam int unsigned RANK_W     = 4;

  typedef logic [SLOT_IDX_W-1:0] slot_idx_t;
  typedef logic [RANK_W-1:0]     rank_t;
  typedef logic [SLOT_CNT-1:0]   slot_map_t;

  // Slots that carry a rate: legacy 0..3, multicarrier 8..15
  localparam slot_map_t SLOT_USED   = 16'hFF0F;
  localparam slot_idx_t LOWEST_SLOT = '0;

  // Speed rank of each slot (0 = slowest); unused slots rank 0
  function automatic rank_t slot_rank(slot_idx_t s);
    case (s)
      4'd0:    return rank_t'(0);   // 1
      4'd1:    return rank_t'(1);   // 2
      4'd2:    return rank_t'(2);   // 5.5
      4'd8:    return rank_t'(3);   // 6
      4'd9:    return rank_t'(4);   // 9
      4'd3:    return rank_t'(5);   // 11
      4'd10:   return rank_t'(6);   // 12
      4'd11:   return rank_t'(7);   // 18
      4'd12:   return rank_t'(8);   // 24
      4'd13:   return rank_t'(9);   // 36
      4'd14:   return rank_t'(10);  // 48
      4'd15:   return rank_t'(11);  // 54
      default: return rank_t'(0);
    endcase
  endfunction

  function automatic logic slot_defined(slot_idx_t s);
    return SLOT_USED[s];
  endfunction

endpackage

// File: rtl/rrs_rst_sync.sv
module rrs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rrs_cap_mask.sv
module rrs_cap_mask
  import rrs_pkg::*;
(
  input  slot_idx_t rx_slot,
  output slot_map_t cap_map
);
  rank_t rx_rank;
  assign rx_rank = slot_rank(rx_slot);

  for (genvar g = 0; g < SLOT_CNT; g++) begin : g_slot
    localparam slot_idx_t G_IDX = slot_idx_t'(g);
    assign cap_map[g] = SLOT_USED[g] && (slot_rank(G_IDX) <= rx_rank);
  end
endmodule

// File: rtl/rrs_fastest_pick.sv
module rrs_fastest_pick
  import rrs_pkg::*;
(
  input  slot_map_t cand,
  output logic      found,
  output slot_idx_t pick
);
  rank_t best_rank;

  always_comb begin
    found     = 1'b0;
    pick      = LOWEST_SLOT;
    best_rank = '0;
    for (int i = 0; i < SLOT_CNT; i++) begin
      if (cand[i] && (!found || (slot_rank(slot_idx_t'(i)) > best_rank))) begin
        found     = 1'b1;
        pick      = slot_idx_t'(i);
        best_rank = slot_rank(slot_idx_t'(i));
      end
    end
  end
endmodule

// File: rtl/rrs_resp_rate_sel.sv
module rrs_resp_rate_sel
  import rrs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic [3:0]  rx_slot_i,
  input  logic [15:0] basic_map_i,
  input  logic [15:0] mand_map_i,
  output logic        rsp_valid_o,
  output logic [3:0]  rsp_slot_o,
  output logic        rsp_err_o
);
  logic      rst_sync_n;
  slot_map_t cap_map;
  slot_map_t basic_cand;
  slot_map_t mand_cand;
  logic      basic_found;
  logic      mand_found;
  slot_idx_t basic_pick;
  slot_idx_t mand_pick;
  logic      rx_ok;

  slot_idx_t slot_d, slot_q;
  logic      err_d, err_q;
  logic      valid_d, valid_q;
  logic      load_en;

  rrs_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rrs_cap_mask u_cap (
    .rx_slot (rx_slot_i),
    .cap_map (cap_map)
  );

  assign basic_cand = basic_map_i & cap_map;
  assign mand_cand  = mand_map_i  & cap_map;

  rrs_fastest_pick u_pick_basic (
    .cand  (basic_cand),
    .found (basic_found),
    .pick  (basic_pick)
  );

  rrs_fastest_pick u_pick_mand (
    .cand  (mand_cand),
    .found (mand_found),
    .pick  (mand_pick)
  );

  assign rx_ok   = slot_defined(rx_slot_i);
  assign load_en = req_i;

  always_comb begin
    valid_d = req_i;
    slot_d  = slot_q;
    err_d   = err_q;
    if (load_en) begin
      if (!rx_ok) begin
        slot_d = LOWEST_SLOT;
        err_d  = 1'b1;
      end else if (basic_found) begin
        slot_d = basic_pick;
        err_d  = 1'b0;
      end else if (mand_found) begin
        slot_d = mand_pick;
        err_d  = 1'b0;
      end else begin
        slot_d = LOWEST_SLOT;
        err_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      slot_q  <= LOWEST_SLOT;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (load_en) begin
        slot_q <= slot_d;
        err_q  <= err_d;
      end
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_slot_o  = slot_q;
  assign rsp_err_o   = err_q;
endmodule

// File: rtl/rrs_resp_rate_sel_chk.sv
module rrs_resp_rate_sel_chk
  import rrs_pkg::*;
(
  input logic        clk,
  input logic        rst_sync_n,
  input logic        req_i,
  input logic [3:0]  rx_slot_i,
  input logic        rsp_valid_o,
  input logic [3:0]  rsp_slot_o,
  input logic        rsp_err_o
);
  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_i |=> rsp_valid_o); // R2

  AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_i |=> !rsp_valid_o); // R2

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_i |=> ($stable(rsp_slot_o) && $stable(rsp_err_o))); // R9

  AST_ERR_LOWEST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid_o && rsp_err_o) |-> (rsp_slot_o == 4'd0)); // R6

  AST_BAD_INDEX: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && !slot_defined(rx_slot_i)) |=> rsp_err_o); // R7

  AST_NO_UNUSED_SLOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid_o && !rsp_err_o) |-> slot_defined(rsp_slot_o)); // R8

  AST_NOT_FASTER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && slot_defined(rx_slot_i)) |=>
      (rsp_err_o || (slot_rank(rsp_slot_o) <= slot_rank($past(rx_slot_i))))); // R3
endmodule

bind rrs_resp_rate_sel rrs_resp_rate_sel_chk u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .req_i       (req_i),
  .rx_slot_i   (rx_slot_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_slot_o  (rsp_slot_o),
  .rsp_err_o   (rsp_err_o)
);

// File: tb/rrs_resp_rate_sel_bench.sv
`timescale 1ns/1ps
module rrs_resp_rate_sel_bench;
  logic        clk;
  logic        rst_n;
  logic        req_i;
  logic [3:0]  rx_slot_i;
  logic [15:0] basic_map_i;
  logic [15:0] mand_map_i;
  logic        rsp_valid_o;
  logic [3:0]  rsp_slot_o;
  logic        rsp_err_o;

  int checks;
  int errors;
  bit done;

  rrs_resp_rate_sel u_rrs_resp_rate_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .rx_slot_i   (rx_slot_i),
    .basic_map_i (basic_map_i),
    .mand_map_i  (mand_map_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_slot_o  (rsp_slot_o),
    .rsp_err_o   (rsp_err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Rate in half-Mb/s units per slot; 0 = no rate
  function automatic int half_mbps(input int s);
    case (s)
      0: return 2;   1: return 4;   2: return 11;  3: return 22;
      8: return 12;  9: return 18;  10: return 24; 11: return 36;
      12: return 48; 13: return 72; 14: return 96; 15: return 108;
      default: return 0;
    endcase
  endfunction

  // Expected {err, slot}
  function automatic logic [4:0] model(input logic [15:0] b, input logic [15:0] m,
                                       input logic [3:0] rx);
    int lim, best, bsl;
    lim = half_mbps(int'(rx));
    if (lim == 0) return {1'b1, 4'd0};
    best = 0; bsl = 0;
    for (int s = 0; s < 16; s++)
      if (b[s] && half_mbps(s) != 0 && half_mbps(s) <= lim && half_mbps(s) > best) begin
        best = half_mbps(s); bsl = s;
      end
    if (best != 0) return {1'b0, 4'(bsl)};
    for (int s = 0; s < 16; s++)
      if (m[s] && half_mbps(s) != 0 && half_mbps(s) <= lim && half_mbps(s) > best) begin
        best = half_mbps(s); bsl = s;
      end
    if (best != 0) return {1'b0, 4'(bsl)};
    return {1'b1, 4'd0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input string tag, input logic [15:0] b, input logic [15:0] m,
                        input logic [3:0] rx);
    logic [4:0] e;
    e = model(b, m, rx);
    @(negedge clk);
    basic_map_i = b; mand_map_i = m; rx_slot_i = rx; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    check({tag, " R2 valid"}, 32'(rsp_valid_o), 32'd1);
    check({tag, " slot"}, 32'(rsp_slot_o), 32'(e[3:0]));
    check({tag, " err"}, 32'(rsp_err_o), 32'(e[4]));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] hold_slot;
    logic       hold_err;
    checks = 0; errors = 0; done = 0;
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_i = 1'b0; rx_slot_i = '0; basic_map_i = '0; mand_map_i = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(rsp_valid_o), 32'd0);
    check("R1 reset slot", 32'(rsp_slot_o), 32'd0);
    check("R1 reset err", 32'(rsp_err_o), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release valid", 32'(rsp_valid_o), 32'd0);
    check("R1 after release err", 32'(rsp_err_o), 32'd0);

    // R3: fastest basic rate at or below 36 -> 18 (slot 11)
    do_req("R3 mixed basic", 16'h0F0F, 16'h0000, 4'd13);
    check("R3 exact slot", 32'(rsp_slot_o), 32'd11);
    // R4: speed order, 9 below 11
    do_req("R4 rx9", 16'h0308, 16'h0000, 4'd9);
    check("R4 rx9 slot", 32'(rsp_slot_o), 32'd9);
    do_req("R4 rx11", 16'h0308, 16'h0000, 4'd3);
    check("R4 rx11 slot", 32'(rsp_slot_o), 32'd3);
    do_req("R4 ofdm under 11", 16'h0300, 16'h0000, 4'd3);
    check("R4 9M under 11M", 32'(rsp_slot_o), 32'd9);
    // R5: fallback to mandatory
    do_req("R5 fallback", 16'hF000, 16'h0103, 4'd10);
    check("R5 slot 6M", 32'(rsp_slot_o), 32'd8);
    // R6: none qualifies
    do_req("R6 none", 16'hF000, 16'h0800, 4'd2);
    check("R6 err", 32'(rsp_err_o), 32'd1);
    // R7: invalid received index
    do_req("R7 bad idx", 16'hFF0F, 16'hFF0F, 4'd5);
    check("R7 err", 32'(rsp_err_o), 32'd1);
    do_req("R7 bad idx7", 16'hFFFF, 16'hFFFF, 4'd7);
    // R8: unused bits in maps ignored
    do_req("R8 unused basic", 16'h00F0, 16'h0001, 4'd15);
    check("R8 slot 1M", 32'(rsp_slot_o), 32'd0);
    check("R8 no err", 32'(rsp_err_o), 32'd0);
    do_req("R8 unused both", 16'h00F0, 16'h00F0, 4'd15);
    check("R8 both err", 32'(rsp_err_o), 32'd1);
    // R2/R9: valid drops, result held while inputs move
    do_req("R9 setup", 16'h0004, 16'h0000, 4'd15);
    hold_slot = rsp_slot_o; hold_err = rsp_err_o;
    for (int k = 0; k < 4; k++) begin
      basic_map_i = 16'($urandom); mand_map_i = 16'($urandom); rx_slot_i = 4'($urandom);
      @(negedge clk);
      check("R2 valid low", 32'(rsp_valid_o), 32'd0);
      check("R9 slot held", 32'(rsp_slot_o), 32'(hold_slot));
      check("R9 err held", 32'(rsp_err_o), 32'(hold_err));
    end
    // Random mix, some back-to-back
    for (int n = 0; n < 400; n++) begin
      do_req("R3 R5 random", 16'($urandom), 16'($urandom), 4'($urandom));
    end
    for (int n = 0; n < 200; n++) begin
      do_req("R4 sparse random", 16'($urandom) & 16'($urandom) & 16'hFF0F,
             16'($urandom) & 16'($urandom), 4'($urandom));
      if ((n % 5) == 0) begin
        @(negedge clk);
        check("R2 gap valid low", 32'(rsp_valid_o), 32'd0);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule